// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates 32 interrupt request positions for a single processor core and tracks which handlers are currently running. Hardware request lines 0 to 25 are sampled as level sources and latched into pending bits. Lines 26 to 31 are ignored, so those positions become pending only through a software write. A word-wide register port gives software control over the enable bits, the pending bits and a 2-bit urgency level per interrupt. The same port reads back the enable, pending, active and level state.

Each cycle the controller chooses the best enabled, pending and not-active interrupt. The lowest level number wins, and among equal levels the lowest IRQ number wins. It raises `take_req` with that number when the choice is strictly more urgent than the level now running. When the core answers with `take_ack`, the interrupt moves from pending to active and its number is pushed onto a small nesting stack. A pulse on `exc_ret` retires the most recently taken interrupt, and the interrupted level resumes.

Register word addresses on `bus_addr`: 0 sets enable bits, 1 clears enable bits, 2 sets pending bits and 3 clears pending bits, all with write-1 semantics. Reading 0 or 1 returns the enable bits, reading 2 or 3 returns the pending bits, and reading 4 returns the active bits. Addresses 8 to 15 hold the levels: word 8+w covers IRQs 4w to 4w+3, and byte b of that word belongs to IRQ 4w+b. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Hardware lines 0 to 25 set their pending bit one cycle after being seen high while the IRQ is not active; lines 26 to 31 never set a pending bit.
- R2: A write to address 2 makes every IRQ pending whose data bit is 1, including 26 to 31, and such an IRQ is then signalled like a hardware one; a write to address 3 clears the pending bits whose data bit is 1.
- R3: In each level byte only bits 7:6 are stored; bits 5:0 of every byte read back as zero whatever was written.
- R4: Among candidates, a numerically lower level is chosen over a higher one regardless of IRQ number.
- R5: Among candidates of equal level, the lowest IRQ number is chosen.
- R6: An IRQ whose enable bit is clear (address 0 sets, address 1 clears) is never signalled on `take_req`, while its pending bit still reads as 1.
- R7: `take_req` is raised only when the choice is strictly more urgent than the running level, or nothing is running; a request at the running level waits.
- R8: When `take_req` and `take_ack` are both high and `exc_ret` is low, the chosen IRQ's pending bit clears and its active bit sets at the edge. `run_idle`/`run_level` then report the most urgent level among active IRQs.
- R9: `exc_ret` clears the active bit of the most recently taken IRQ still active (last in, first out, four deep), restoring the interrupted level. When nothing is active it has no effect, and it takes precedence over a same-cycle `take_ack`.
- R10: A level line still high when its handler returns becomes pending again one cycle after the return and is signalled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level request lines; bits 26 to 31 ignored |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| take_req | output | 1 | Request to the core to take an interrupt |
| take_id | output | 5 | IRQ number offered with `take_req` |
| take_ack | input | 1 | Core accepts the offered interrupt |
| exc_ret | input | 1 | Core exception-return strobe |
| run_idle | output | 1 | No interrupt active |
| run_level | output | 2 | Level currently running (valid when not idle) |

## Verification
Directed patterns each target one behaviour. Two equal-level requests tell the tie rule apart from the level rule, and the pair is then re-levelled so the higher number must win. All lines raised at once separate the wired positions from the six dead ones. A disabled but pending source shows masking without loss of the pending state. A three-handler sequence with one equal-level arrival distinguishes strict preemption from mere arrival and checks resumption order. A held line across a return shows re-pending. Long random runs mix bus writes, line activity, acknowledges and returns, including returns with nothing active and returns that collide with an acknowledge. Every cycle is compared against a reference model of the requirements.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int IRQ_COUNT = 32;
    localparam int ID_W      = $clog2(IRQ_COUNT);
    localparam int LVL_W     = 2;
    localparam int ADDR_W    = 4;

    typedef enum logic [2:0] {
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_ACT,
        SEL_PRIO,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        logic             found;
        logic [ID_W-1:0]  id;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        sel_e s;
        if (a[3]) begin
            s = SEL_PRIO;
        end else begin
            case (a[2:0])
                3'd0:    s = SEL_EN_SET;
                3'd1:    s = SEL_EN_CLR;
                3'd2:    s = SEL_PD_SET;
                3'd3:    s = SEL_PD_CLR;
                3'd4:    s = SEL_ACT;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [IRQ_COUNT-1:0] low_ones(input int n);
        logic [IRQ_COUNT-1:0] m;
        for (int i = 0; i < IRQ_COUNT; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int N  = IRQ_COUNT,
    parameter int LW = LVL_W
) (
    input  logic [N-1:0]    mask,
    input  logic [N*LW-1:0] prio_flat,
    output pick_t           best
);
    always_comb begin
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!best.found || prio_flat[i*LW +: LW] < best.lvl)) begin
                best.found = 1'b1;
                best.id    = ID_W'(i);
                best.lvl   = prio_flat[i*LW +: LW];
            end
        end
    end
endmodule

// File: rtl/irqc_lifo.sv
module irqc_lifo
    import irqc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IW    = ID_W,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [IW-1:0] push_id,
    input  logic          pop,
    output logic [IW-1:0] top_id,
    output logic [PW-1:0] depth,
    output logic          full
);
    logic [IW-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else if (pop && depth != '0) begin
            depth <= depth - 1'b1;
        end else if (push && !full) begin
            depth <= depth + 1'b1;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[k] <= '0;
            end else if (push && !pop && depth == PW'(k)) begin
                slot_q[k] <= push_id;
            end
        end
    end

    always_comb begin
        top_id = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (depth == PW'(k + 1)) begin
                top_id = slot_q[k];
            end
        end
    end

    assign full = (depth == PW'(DEPTH));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N        = IRQ_COUNT,
    parameter int LW       = LVL_W,
    parameter int HW_LINES = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      lines,
    input  logic [N-1:0]      acc_vec,
    input  logic [N-1:0]      ret_vec,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      pend_q,
    output logic [N-1:0]      act_q,
    output logic [N*LW-1:0]   prio_flat,
    output logic [N-1:0]      rdata
);
    localparam logic [N-1:0] HW_MASK = low_ones(HW_LINES);

    sel_e         sel;
    logic [N-1:0] hw_req;
    logic [N-1:0] set_pd, clr_pd;
    logic [N-1:0] prio_word;

    assign sel    = decode_addr(addr);
    assign hw_req = lines & HW_MASK & ~act_q;
    assign set_pd = (wr && sel == SEL_PD_SET) ? wdata : '0;
    assign clr_pd = (wr && sel == SEL_PD_CLR) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr && sel == SEL_EN_SET) en_q <= en_q | wdata;
            if (wr && sel == SEL_EN_CLR) en_q <= en_q & ~wdata;
            pend_q <= (pend_q | hw_req | set_pd) & ~clr_pd & ~acc_vec;
            act_q  <= (act_q | acc_vec) & ~ret_vec;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_prio
        localparam int W = i / 4;
        localparam int B = i % 4;
        logic [LW-1:0] lvl_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= '0;
            end else if (wr && sel == SEL_PRIO && addr[2:0] == 3'(W)) begin
                lvl_q <= wdata[8*B+7 -: LW];
            end
        end
        assign prio_flat[i*LW +: LW] = lvl_q;
    end

    always_comb begin
        prio_word = '0;
        for (int i = 0; i < N; i++) begin
            if (addr[2:0] == 3'(i / 4)) begin
                prio_word[8*(i%4)+7 -: LW] = prio_flat[i*LW +: LW];
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_EN_SET, SEL_EN_CLR: rdata = en_q;
            SEL_PD_SET, SEL_PD_CLR: rdata = pend_q;
            SEL_ACT:                rdata = act_q;
            SEL_PRIO:               rdata = prio_word;
            default:                rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irqc_pkg::*;
#(
    parameter int HW_LINES   = 26,
    parameter int NEST_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_COUNT-1:0] irq_lines,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [IRQ_COUNT-1:0] bus_wdata,
    output logic [IRQ_COUNT-1:0] bus_rdata,
    output logic                 take_req,
    output logic [ID_W-1:0]      take_id,
    input  logic                 take_ack,
    input  logic                 exc_ret,
    output logic                 run_idle,
    output logic [LVL_W-1:0]     run_level
);
    localparam int PW = $clog2(NEST_DEPTH + 1);

    logic [IRQ_COUNT-1:0]       en_q, pend_q, act_q;
    logic [IRQ_COUNT*LVL_W-1:0] prio_flat;
    logic [IRQ_COUNT-1:0]       acc_vec, ret_vec;
    pick_t                      win, run;
    logic [LVL_W-1:0]           win_lvl;
    logic [ID_W-1:0]            top_id;
    logic [PW-1:0]              depth;
    logic                       full, accept, retire;

    irqc_regs #(.N(IRQ_COUNT), .LW(LVL_W), .HW_LINES(HW_LINES)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .lines(irq_lines), .acc_vec(acc_vec), .ret_vec(ret_vec),
        .en_q(en_q), .pend_q(pend_q), .act_q(act_q), .prio_flat(prio_flat),
        .rdata(bus_rdata)
    );

    irqc_pick #(.N(IRQ_COUNT), .LW(LVL_W)) u_win (
        .mask(pend_q & en_q & ~act_q), .prio_flat(prio_flat), .best(win)
    );

    irqc_pick #(.N(IRQ_COUNT), .LW(LVL_W)) u_run (
        .mask(act_q), .prio_flat(prio_flat), .best(run)
    );

    irqc_lifo #(.DEPTH(NEST_DEPTH), .IW(ID_W)) u_stack (
        .clk(clk), .rst(rst), .push(accept), .push_id(win.id), .pop(retire),
        .top_id(top_id), .depth(depth), .full(full)
    );

    assign win_lvl   = win.lvl;
    assign run_idle  = !run.found;
    assign run_level = run.lvl;
    assign take_req  = win.found && !full && (!run.found || win.lvl < run.lvl);
    assign take_id   = win.id;
    assign retire    = exc_ret && depth != '0;
    assign accept    = take_req && take_ack && !exc_ret;
    assign acc_vec   = accept ? (IRQ_COUNT'(1) << win.id) : '0;
    assign ret_vec   = retire ? (IRQ_COUNT'(1) << top_id) : '0;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int PW = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 take_req,
    input logic [ID_W-1:0]      take_id,
    input logic                 take_ack,
    input logic                 exc_ret,
    input logic [IRQ_COUNT-1:0] en,
    input logic [IRQ_COUNT-1:0] pend,
    input logic [IRQ_COUNT-1:0] act,
    input logic                 run_idle,
    input logic [LVL_W-1:0]     run_level,
    input logic [LVL_W-1:0]     win_lvl,
    input logic [PW-1:0]        depth,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [IRQ_COUNT-1:0] bus_rdata
);
    localparam logic [7:0]  LOW_BYTE = 8'hFF >> LVL_W;
    localparam logic [31:0] LOW_MASK = {4{LOW_BYTE}};

    // R6
    masked_take_chk: assert property (@(posedge clk) disable iff (rst)
        take_req |-> en[take_id]);

    // R7
    strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        take_req |-> (run_idle || win_lvl < run_level));

    // R8
    accept_move_chk: assert property (@(posedge clk) disable iff (rst)
        (take_req && take_ack && !exc_ret) |=> (act[$past(take_id)] && !pend[$past(take_id)]));

    // R9
    return_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_ret && depth != '0) |=> (depth == PW'($past(depth) - 1'b1)));

    // R3
    prio_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr[3] |-> ((bus_rdata & LOW_MASK) == '0));
endmodule

bind irq_nest_ctrl irqc_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst(rst), .take_req(take_req), .take_id(take_id),
    .take_ack(take_ack), .exc_ret(exc_ret), .en(en_q), .pend(pend_q),
    .act(act_q), .run_idle(run_idle), .run_level(run_level),
    .win_lvl(win_lvl), .depth(depth), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_lines = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        take_req;
    logic [4:0]  take_id;
    logic        take_ack = 1'b0;
    logic        exc_ret = 1'b0;
    logic        run_idle;
    logic [1:0]  run_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .take_req(take_req), .take_id(take_id), .take_ack(take_ack),
        .exc_ret(exc_ret), .run_idle(run_idle), .run_level(run_level)
    );

    // reference state
    logic [31:0] m_en, m_pd, m_act;
    logic [1:0]  m_pr [32];
    int          m_stk [4];
    int          m_dep;
    localparam logic [31:0] HWM = 32'h03FF_FFFF;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_eval(output bit f, output int wid, output int wl,
                              output bit idle, output int rl, output bit req);
        f = 0; wid = 0; wl = 0; idle = 1; rl = 0;
        for (int i = 0; i < 32; i++) begin
            if (m_pd[i] && m_en[i] && !m_act[i] && (!f || int'(m_pr[i]) < wl)) begin
                f = 1; wid = i; wl = int'(m_pr[i]);
            end
            if (m_act[i] && (idle || int'(m_pr[i]) < rl)) begin
                idle = 0; rl = int'(m_pr[i]);
            end
        end
        req = f && (idle || wl < rl) && m_dep < 4;
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r = '0;
        if (a[3]) begin
            for (int b = 0; b < 4; b++) r[8*b+6 +: 2] = m_pr[4*a[2:0]+b];
        end else if (a[2:0] < 2) r = m_en;
        else if (a[2:0] < 4) r = m_pd;
        else if (a[2:0] == 4) r = m_act;
        return r;
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        if (a[3]) return "R3";
        if (a[2:0] < 2) return "R6";
        if (a[2:0] < 4) return "R2";
        return "R8";
    endfunction

    task automatic model_reset();
        m_en = '0; m_pd = '0; m_act = '0; m_dep = 0;
        for (int i = 0; i < 32; i++) m_pr[i] = '0;
        for (int k = 0; k < 4; k++) m_stk[k] = 0;
    endtask

    // called at a negedge with inputs set; compares, then advances one edge
    task automatic tick();
        bit f, idle, req; int wid, wl, rl;
        logic [31:0] acc, retv, hw, nxt_pd;
        #2;
        model_eval(f, wid, wl, idle, rl, req);
        chk(take_req === req, "R7 take_req", 32'(take_req), 32'(req));
        if (req) chk(take_id === 5'(wid), "R4 R5 take_id", 32'(take_id), 32'(wid));
        chk(run_idle === idle, "R8 run_idle", 32'(run_idle), 32'(idle));
        if (!idle) chk(run_level === 2'(rl), "R8 run_level", 32'(run_level), 32'(rl));
        chk(bus_rdata === model_read(bus_addr), rd_tag(bus_addr), bus_rdata, model_read(bus_addr));
        @(posedge clk);
        acc  = (req && take_ack && !exc_ret) ? (32'd1 << wid) : '0;
        retv = (exc_ret && m_dep > 0) ? (32'd1 << m_stk[m_dep-1]) : '0;
        hw   = irq_lines & HWM & ~m_act;
        nxt_pd = m_pd | hw;
        if (bus_wr && !bus_addr[3] && bus_addr[2:0] == 2) nxt_pd = nxt_pd | bus_wdata;
        if (bus_wr && !bus_addr[3] && bus_addr[2:0] == 3) nxt_pd = nxt_pd & ~bus_wdata;
        m_pd = nxt_pd & ~acc;
        if (bus_wr && !bus_addr[3] && bus_addr[2:0] == 0) m_en = m_en | bus_wdata;
        if (bus_wr && !bus_addr[3] && bus_addr[2:0] == 1) m_en = m_en & ~bus_wdata;
        if (bus_wr && bus_addr[3])
            for (int b = 0; b < 4; b++) m_pr[4*bus_addr[2:0]+b] = bus_wdata[8*b+6 +: 2];
        m_act = (m_act | acc) & ~retv;
        if (retv != 0) m_dep--;
        else if (acc != 0) begin m_stk[m_dep] = wid; m_dep++; end
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic unwind();
        take_ack = 0;
        while (m_dep > 0) begin exc_ret = 1; tick(); end
        exc_ret = 0;
        irq_lines = '0;
        wr_reg(4'd1, 32'hFFFF_FFFF);
        wr_reg(4'd3, 32'hFFFF_FFFF);
        wr_reg(4'd3, 32'hFFFF_FFFF);
    endtask

    initial begin
        #180000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state
        #1;
        chk(take_req === 1'b0, "R8 reset take_req", 32'(take_req), 0);
        chk(run_idle === 1'b1, "R8 reset run_idle", 32'(run_idle), 1);
        tick();

        // R1: all lines high, only wired ones latch
        irq_lines = '1; tick(); tick();
        irq_lines = '0; bus_addr = 4'd2; #1;
        chk(bus_rdata === 32'h03FF_FFFF, "R1 hw pend", bus_rdata, 32'h03FF_FFFF);
        tick();
        unwind();

        // R2: software pend of dead positions, signalled
        wr_reg(4'd2, 32'hFC00_0000);
        wr_reg(4'd0, 32'h4000_0000);
        bus_addr = 4'd2; #1;
        chk(bus_rdata === 32'hFC00_0000, "R2 sw pend", bus_rdata, 32'hFC00_0000);
        chk(take_req && take_id == 5'd30, "R2 sw take", 32'(take_id), 30);
        tick();
        unwind();

        // R3: low bits of level bytes read zero
        wr_reg(4'd8, 32'hFFFF_FFFF);
        bus_addr = 4'd8; #1;
        chk(bus_rdata === 32'hC0C0_C0C0, "R3 prio readback", bus_rdata, 32'hC0C0_C0C0);
        tick();
        wr_reg(4'd8, 32'h0);

        // R5: tie -> lowest number; R4: level beats number
        wr_reg(4'd8, 32'h8000_0000);          // irq3 level 2
        wr_reg(4'd9, 32'h8000_0000);          // irq7 level 2
        wr_reg(4'd0, 32'h0000_0088);
        wr_reg(4'd2, 32'h0000_0088);
        #1; chk(take_req && take_id == 5'd3, "R5 tie", 32'(take_id), 3);
        tick();
        wr_reg(4'd9, 32'h4000_0000);          // irq7 level 1
        #1; chk(take_req && take_id == 5'd7, "R4 level", 32'(take_id), 7);
        tick();

        // R6: masked but pending
        wr_reg(4'd1, 32'h0000_0088);
        bus_addr = 4'd2; #1;
        chk(!take_req, "R6 masked", 32'(take_req), 0);
        chk(bus_rdata[3] && bus_rdata[7], "R6 still pending", bus_rdata, 32'h88);
        tick();
        unwind();

        // R7/R8/R9: nesting
        wr_reg(4'd9,  32'h0000_8000);         // irq5 level 2
        wr_reg(4'd10, 32'h0000_4000);         // irq9 level 1
        wr_reg(4'd11, 32'h0000_0040);         // irq12 level 1
        wr_reg(4'd0, 32'h0000_1220);
        wr_reg(4'd2, 32'h0000_0020);
        take_ack = 1; tick(); take_ack = 0;
        bus_addr = 4'd4; #1;
        chk(bus_rdata === 32'h20 && run_level == 2, "R8 accept", bus_rdata, 32'h20);
        tick();
        wr_reg(4'd2, 32'h0000_0200);
        #1; chk(take_req && take_id == 5'd9, "R7 preempt", 32'(take_id), 9);
        take_ack = 1; tick(); take_ack = 0;
        wr_reg(4'd2, 32'h0000_1000);
        #1; chk(!take_req && run_level == 1, "R7 equal waits", 32'(take_req), 0);
        exc_ret = 1; tick(); exc_ret = 0;
        #1; chk(run_level == 2 && take_req && take_id == 5'd12, "R9 resume", 32'(run_level), 2);
        take_ack = 1; tick(); take_ack = 0;
        exc_ret = 1; tick(); tick(); exc_ret = 0;
        #1; chk(run_idle, "R9 unwind", 32'(run_idle), 1);
        exc_ret = 1; tick(); exc_ret = 0;     // empty return ignored
        #1; chk(run_idle && !take_req, "R9 empty return", 32'(take_req), 0);
        tick();
        unwind();

        // R10: held line re-pends after return
        wr_reg(4'd9, 32'h0000_00C0);          // irq4 level 3
        wr_reg(4'd0, 32'h0000_0010);
        irq_lines = 32'h10; tick();
        take_ack = 1; tick(); take_ack = 0;
        #1; chk(!take_req, "R10 active no req", 32'(take_req), 0);
        tick();
        exc_ret = 1; tick(); exc_ret = 0;
        tick();
        #1; chk(take_req && take_id == 5'd4, "R10 retaken", 32'(take_id), 4);
        tick();
        unwind();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            irq_lines = ($urandom % 4 == 0) ? $urandom : irq_lines;
            bus_wr    = ($urandom % 4 == 0);
            bus_addr  = ($urandom % 2) ? 4'(8 + $urandom % 8) : 4'($urandom % 5);
            bus_wdata = ($urandom % 2) ? $urandom : (32'd1 << ($urandom % 32));
            take_ack  = ($urandom % 10) < 7;
            exc_ret   = (m_dep > 0) ? ($urandom % 5 == 0) : ($urandom % 20 == 0);
            tick();
        end
        bus_wr = 0; take_ack = 0; exc_ret = 0;
        tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule